// File: doc/BRIEF.md
# Two-Phase Piezo Burst Generator

This block drives a resonant piezo motor with two square-wave phases that are offset by part of a period. Writing a pulse count together with a direction bit starts a burst. The generator then runs that many periods and goes back to idle with every output low. All timing is counted in system-clock cycles. The period, the high time and the offset of the lagging phase all come from configuration inputs, so the drive frequency can be set close to the motor resonance. At a 200 MHz clock, a resonance near 172 kHz is a period of about 1163 cycles.

Each phase has a high-side and a low-side output. On a full-bridge period the low side carries the complement of the phase. On a half-bridge period the low side stays low. A ratio input sets what fraction of periods are full-bridge. An accumulator spreads the full-bridge periods evenly across the burst, which sets the average voltage the motor sees. The direction bit selects which leg leads. The block latches its settings when a burst starts, so software can prepare the next burst while the current one runs.

Top module: `piezo_burst_gen`

## Requirements
- R1: After reset, and in every cycle in which `busy` is low, all four drive outputs are low.
- R2: A write with count N≥1 on `pulse_wr` makes `busy` high from the next cycle for exactly N·P cycles. P is the latched period: `cfg_period`, raised to 4 if it is smaller.
- R3: In each period the leading leg's high side is high during cycles 0 to W-1 of the period. W is `cfg_width`, except that a value of 0 or a value above floor(P/2) gives W = floor(P/2).
- R4: The lagging leg's high side is high during cycles S to S+W-1 of each period. S is `cfg_shift`, except that 0 gives S = floor(P/4), and S is clamped to at most P-W.
- R5: `pulse_dir` = 0 makes leg A lead and leg B lag. `pulse_dir` = 1 swaps the two legs.
- R6: On a full-bridge period, a leg's low side is the complement of its high side while busy. On a half-bridge period, the low side stays low. A leg never has both sides high in the same cycle.
- R7: With ratio r = min(`cfg_hybrid`, 2^HYB_W), period k of the burst (counting from 0) is full-bridge exactly when floor((k+1)·r/2^HYB_W) − floor(k·r/2^HYB_W) = 1. The accumulator restarts at every burst start.
- R8: A write with count 0 produces no drive. If a burst is running, that write ends it, and the block is idle from the next cycle.
- R9: A write during a burst restarts the burst from cycle 0 of period 0, using the new count, direction and settings.
- R10: Changes on the configuration inputs while no write occurs have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_wr | input | 1 | Write strobe for the pulse count; starts, restarts or stops a burst |
| pulse_cnt | input | CNT_W | Number of periods in the burst |
| pulse_dir | input | 1 | Direction: 0 makes leg A lead, 1 makes leg B lead |
| cfg_period | input | PER_W | Period in clock cycles |
| cfg_width | input | PER_W | High time in cycles; 0 selects half period |
| cfg_shift | input | PER_W | Lagging-leg offset in cycles; 0 selects quarter period |
| cfg_hybrid | input | HYB_W+1 | Full-bridge ratio out of 2^HYB_W |
| busy | output | 1 | High while a burst runs |
| a_hi | output | 1 | Leg A high side |
| a_lo | output | 1 | Leg A low side |
| b_hi | output | 1 | Leg B high side |
| b_lo | output | 1 | Leg B low side |

## Verification
The bench targets the clamps. These cases are a width larger than half the period, a shift that would push the lagging pulse past the period end, and a period below four cycles. A design that got any of them wrong would produce a lagging pulse that wraps into the next period, or a burst of the wrong length. The bench also covers ratio values of zero, exactly full scale and above full scale. An off-by-one or a missing clamp in the accumulator would misplace full-bridge periods or drop one. Restarts and zero-count writes in the middle of a burst are included, because a timer that failed to reset its phase, remaining count or accumulator would finish the old burst or run the new one from the wrong place. Random bursts change the configuration inputs straight after the start, to catch settings that are not latched.

// File: rtl/pzb_pkg.sv
`timescale 1ns/1ps
package pzb_pkg;
   localparam int unsigned MIN_PERIOD = 4;
   localparam longint unsigned RES_LOW_HZ = 150000;
   typedef enum logic {LEAD_A = 1'b0, LEAD_B = 1'b1} lead_e;
endpackage

// File: rtl/pzb_cfg_latch.sv
`timescale 1ns/1ps
module pzb_cfg_latch
   import pzb_pkg::*;
#(
   parameter int unsigned PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PER_W-1:0] period_in,
   input  logic [PER_W-1:0] width_in,
   input  logic [PER_W-1:0] shift_in,
   input  logic             dir_in,
   output logic [PER_W-1:0] per_q,
   output logic [PER_W-1:0] wid_q,
   output logic [PER_W-1:0] sft_q,
   output lead_e            dir_q
);
   localparam logic [PER_W-1:0] P_MIN = PER_W'(MIN_PERIOD);

   logic [PER_W-1:0] p_eff, half, w_eff, s_dflt, room, s_eff;

   always_comb begin
      p_eff  = (period_in < P_MIN) ? P_MIN : period_in;
      half   = p_eff >> 1;
      w_eff  = ((width_in == '0) || (width_in > half)) ? half : width_in;
      s_dflt = (shift_in == '0) ? (p_eff >> 2) : shift_in;
      room   = p_eff - w_eff;
      s_eff  = (s_dflt > room) ? room : s_dflt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= P_MIN;
         wid_q <= P_MIN >> 1;
         sft_q <= P_MIN >> 2;
         dir_q <= LEAD_A;
      end else if (load) begin
         per_q <= p_eff;
         wid_q <= w_eff;
         sft_q <= s_eff;
         dir_q <= lead_e'(dir_in);
      end
   end
endmodule

// File: rtl/pzb_timer.sv
`timescale 1ns/1ps
module pzb_timer #(
   parameter int unsigned PER_W = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count_in,
   input  logic [PER_W-1:0] per,
   output logic             busy,
   output logic [PER_W-1:0] ph,
   output logic [CNT_W-1:0] rem,
   output logic             step
);
   logic last_cyc;

   assign last_cyc = (ph == per - PER_W'(1));
   assign step     = busy && last_cyc && (rem != CNT_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ph   <= '0;
         rem  <= '0;
      end else if (load) begin
         busy <= (count_in != '0);
         ph   <= '0;
         rem  <= count_in;
      end else if (busy) begin
         if (last_cyc) begin
            ph <= '0;
            if (rem == CNT_W'(1)) busy <= 1'b0;
            else                  rem  <= rem - CNT_W'(1);
         end else begin
            ph <= ph + PER_W'(1);
         end
      end
   end
endmodule

// File: rtl/pzb_bridge_mix.sv
`timescale 1ns/1ps
module pzb_bridge_mix #(
   parameter int unsigned HYB_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [HYB_W:0] ratio_in,
   output logic           full
);
   localparam logic [HYB_W:0] FULL_SCALE = {1'b1, {HYB_W{1'b0}}};

   logic [HYB_W:0]   r_clamp, ratio_q, sum_run;
   logic [HYB_W-1:0] acc;

   assign r_clamp = (ratio_in > FULL_SCALE) ? FULL_SCALE : ratio_in;
   assign sum_run = {1'b0, acc} + ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= '0;
         acc     <= '0;
         full    <= 1'b0;
      end else if (load) begin
         ratio_q <= r_clamp;
         acc     <= r_clamp[HYB_W-1:0];
         full    <= r_clamp[HYB_W];
      end else if (step) begin
         acc     <= sum_run[HYB_W-1:0];
         full    <= sum_run[HYB_W];
      end
   end
endmodule

// File: rtl/pzb_shaper.sv
`timescale 1ns/1ps
module pzb_shaper #(
   parameter int unsigned PER_W = 16,
   parameter int unsigned LEGS  = 2
) (
   input  logic             busy,
   input  logic             full,
   input  logic             dir_b,
   input  logic [PER_W-1:0] ph,
   input  logic [PER_W-1:0] wid,
   input  logic [PER_W-1:0] sft,
   output logic [LEGS-1:0]  hi,
   output logic [LEGS-1:0]  lo
);
   logic         lead_w, lag_w;
   logic [PER_W:0] ph_x, sft_x, end_x;

   assign ph_x   = {1'b0, ph};
   assign sft_x  = {1'b0, sft};
   assign end_x  = sft_x + {1'b0, wid};
   assign lead_w = busy && (ph < wid);
   assign lag_w  = busy && (ph_x >= sft_x) && (ph_x < end_x);

   for (genvar gi = 0; gi < LEGS; gi++) begin : g_leg
      logic wave;
      if (gi == 0) begin : g_first
         assign wave = dir_b ? lag_w : lead_w;
      end else begin : g_second
         assign wave = dir_b ? lead_w : lag_w;
      end
      assign hi[gi] = wave;
      assign lo[gi] = busy && full && !wave;
   end
endmodule

// File: rtl/piezo_burst_gen.sv
`timescale 1ns/1ps
module piezo_burst_gen
   import pzb_pkg::*;
#(
   parameter longint unsigned CLK_HZ = 200000000,
   parameter int unsigned     PER_W  = 16,
   parameter int unsigned     CNT_W  = 16,
   parameter int unsigned     HYB_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_wr,
   input  logic [CNT_W-1:0] pulse_cnt,
   input  logic             pulse_dir,
   input  logic [PER_W-1:0] cfg_period,
   input  logic [PER_W-1:0] cfg_width,
   input  logic [PER_W-1:0] cfg_shift,
   input  logic [HYB_W:0]   cfg_hybrid,
   output logic             busy,
   output logic             a_hi,
   output logic             a_lo,
   output logic             b_hi,
   output logic             b_lo
);
   localparam int unsigned    LEGS     = 2;
   localparam longint unsigned MAX_PER = (64'd1 << PER_W) - 64'd1;

   if (PER_W < 4 || PER_W > 32) begin : g_bad_per
      $error("PER_W out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (HYB_W < 1 || HYB_W > 16) begin : g_bad_hyb
      $error("HYB_W out of range");
   end
   if (CLK_HZ / RES_LOW_HZ > MAX_PER) begin : g_bad_clk
      $error("PER_W too narrow for resonant period at CLK_HZ");
   end

   logic [PER_W-1:0] per_q, wid_q, sft_q, ph;
   logic [CNT_W-1:0] rem;
   lead_e            dir_q;
   logic             dir_b, step, full;
   logic [LEGS-1:0]  hi, lo;

   assign dir_b = (dir_q == LEAD_B);

   pzb_cfg_latch #(.PER_W(PER_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .load(pulse_wr),
      .period_in(cfg_period), .width_in(cfg_width), .shift_in(cfg_shift),
      .dir_in(pulse_dir),
      .per_q(per_q), .wid_q(wid_q), .sft_q(sft_q), .dir_q(dir_q)
   );

   pzb_timer #(.PER_W(PER_W), .CNT_W(CNT_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .load(pulse_wr), .count_in(pulse_cnt),
      .per(per_q), .busy(busy), .ph(ph), .rem(rem), .step(step)
   );

   pzb_bridge_mix #(.HYB_W(HYB_W)) mix_i (
      .clk(clk), .rst_n(rst_n), .load(pulse_wr), .step(step),
      .ratio_in(cfg_hybrid), .full(full)
   );

   pzb_shaper #(.PER_W(PER_W), .LEGS(LEGS)) shp_i (
      .busy(busy), .full(full), .dir_b(dir_b), .ph(ph),
      .wid(wid_q), .sft(sft_q), .hi(hi), .lo(lo)
   );

   assign a_hi = hi[0];
   assign a_lo = lo[0];
   assign b_hi = hi[1];
   assign b_lo = lo[1];
endmodule

// File: rtl/pzb_checker.sv
`timescale 1ns/1ps
module pzb_checker #(
   parameter int unsigned PER_W = 16,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pulse_wr,
   input logic             busy,
   input logic             a_hi,
   input logic             a_lo,
   input logic             b_hi,
   input logic             b_lo,
   input logic             full,
   input logic             dir_b,
   input logic [PER_W-1:0] ph,
   input logic [PER_W-1:0] per_q,
   input logic [CNT_W-1:0] rem
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(a_hi || a_lo || b_hi || b_lo));

   assert_burst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(pulse_wr) ||
         (($past(ph) == $past(per_q) - PER_W'(1)) && ($past(rem) == CNT_W'(1)))));

   assert_lead_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ph == '0) |-> (dir_b ? (b_hi && !a_hi) : (a_hi && !b_hi)));

   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_hi && a_lo) && !(b_hi && b_lo));

   assert_half_lowside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !full) |-> (!a_lo && !b_lo));

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_wr |=> $stable(per_q));
endmodule

bind piezo_burst_gen pzb_checker #(.PER_W(PER_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .pulse_wr(pulse_wr), .busy(busy),
   .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
   .full(full), .dir_b(dir_b), .ph(ph), .per_q(per_q), .rem(rem)
);

// File: tb/piezo_burst_gen_tb_top.sv
`timescale 1ns/1ps
module piezo_burst_gen_tb_top;
   localparam int PER_W = 16;
   localparam int CNT_W = 16;
   localparam int HYB_W = 8;
   localparam int FS    = 1 << HYB_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pulse_wr = 1'b0;
   logic [CNT_W-1:0] pulse_cnt = '0;
   logic             pulse_dir = 1'b0;
   logic [PER_W-1:0] cfg_period = '0, cfg_width = '0, cfg_shift = '0;
   logic [HYB_W:0]   cfg_hybrid = '0;
   logic             busy, a_hi, a_lo, b_hi, b_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int ep, ew, es, er, ed, en;

   always #2.5 clk = ~clk;

   piezo_burst_gen #(.PER_W(PER_W), .CNT_W(CNT_W), .HYB_W(HYB_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .pulse_wr(pulse_wr), .pulse_cnt(pulse_cnt),
      .pulse_dir(pulse_dir), .cfg_period(cfg_period), .cfg_width(cfg_width),
      .cfg_shift(cfg_shift), .cfg_hybrid(cfg_hybrid),
      .busy(busy), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
   );

   function automatic int eff_p(int p);
      return (p < 4) ? 4 : p;
   endfunction
   function automatic int eff_w(int p, int w);
      int half = p / 2;
      return (w == 0 || w > half) ? half : w;
   endfunction
   function automatic int eff_s(int p, int w, int s);
      int d = (s == 0) ? p / 4 : s;
      return (d > p - w) ? p - w : d;
   endfunction
   function automatic int is_full(int r, int k);
      int rr = (r > FS) ? FS : r;
      return (((k + 1) * rr) / FS) - ((k * rr) / FS);
   endfunction
   // expected {busy, a_hi, a_lo, b_hi, b_lo} at burst cycle k
   function automatic logic [4:0] expect_at(int k);
      int ph, pk;
      logic lead, lag, fb, wa, wb;
      if (k >= en * ep) return 5'b0;
      ph   = k % ep;
      pk   = k / ep;
      lead = ph < ew;
      lag  = (ph >= es) && (ph < es + ew);
      fb   = is_full(er, pk) != 0;
      wa   = ed ? lag : lead;
      wb   = ed ? lead : lag;
      return {1'b1, wa, fb & ~wa, wb, fb & ~wb};
   endfunction

   task automatic check(string req, int k, logic [4:0] act, logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle=%0d act=%b exp=%b", req, k, act, exp);
      end
   endtask

   // called at a negedge; the write is taken at the next posedge
   task automatic start(int p, int w, int s, int r, int dir, int n);
      cfg_period = PER_W'(p);
      cfg_width  = PER_W'(w);
      cfg_shift  = PER_W'(s);
      cfg_hybrid = (HYB_W+1)'(r);
      pulse_dir  = dir[0];
      pulse_cnt  = CNT_W'(n);
      pulse_wr   = 1'b1;
      ep = eff_p(p); ew = eff_w(ep, w); es = eff_s(ep, ew, s);
      er = r; ed = dir; en = n;
      @(posedge clk);
      @(negedge clk);
      pulse_wr = 1'b0;
   endtask

   task automatic span(string req, int cycles);
      for (int j = 0; j < cycles; j++) begin
         check(req, j, {busy, a_hi, a_lo, b_hi, b_lo}, expect_at(j));
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", 0, {busy, a_hi, a_lo, b_hi, b_lo}, 5'b0);
      // R3 defaults, full bridge, A leads
      start(20, 0, 0, 256, 0, 3);  span("R3", 3 * 20 + 3);
      // R5 B leads
      start(20, 0, 0, 256, 1, 3);  span("R5", 3 * 20 + 3);
      // R6 half bridge only
      start(16, 0, 0, 0, 0, 4);    span("R6", 4 * 16 + 2);
      // R7 one-third mix and over-range ratio
      start(12, 0, 0, 85, 1, 12);  span("R7", 12 * 12 + 2);
      start(8, 3, 2, 300, 0, 3);   span("R7", 3 * 8 + 2);
      start(8, 0, 0, 200, 0, 6);   span("R7", 6 * 8 + 2);
      // R3 width clamp, R4 explicit and clamped shift
      start(20, 100, 0, 256, 0, 2); span("R3", 2 * 20 + 2);
      start(24, 4, 7, 256, 1, 2);   span("R4", 2 * 24 + 2);
      start(20, 0, 50, 128, 0, 3);  span("R4", 3 * 20 + 2);
      // R2 period below minimum
      start(2, 0, 0, 256, 0, 3);    span("R2", 3 * 4 + 3);
      // R8 zero count from idle
      start(10, 0, 0, 256, 0, 0);   span("R8", 10);
      // R9 restart mid-burst
      start(10, 0, 0, 256, 0, 5);   span("R9", 13);
      start(14, 5, 3, 128, 1, 2);   span("R9", 2 * 14 + 3);
      // R8 zero count ends a running burst
      start(10, 0, 0, 256, 0, 5);   span("R8", 7);
      start(10, 0, 0, 256, 0, 0);   span("R8", 6);
      // R10 random bursts with inputs scrambled after start
      for (int i = 0; i < 25; i++) begin
         int p = 4 + int'($urandom % 37);
         int w = int'($urandom % 26);
         int s = int'($urandom % 31);
         int r = int'($urandom % 301);
         int d = int'($urandom % 2);
         int n = 1 + int'($urandom % 6);
         start(p, w, s, r, d, n);
         cfg_period = PER_W'($urandom % 64);
         cfg_width  = PER_W'($urandom % 64);
         cfg_shift  = PER_W'($urandom % 64);
         cfg_hybrid = (HYB_W+1)'($urandom % 512);
         pulse_dir  = ~pulse_dir;
         pulse_cnt  = CNT_W'($urandom % 9);
         span("R10", n * ep + 2);
      end
      finish_run();
   end
endmodule